// File: doc/BRIEF.md
# Virtual Function Routing ID Generator

This block turns the device/function number of a physical function, together with the offset and stride that software programs for its virtual functions, into the device/function number of any one virtual function. A lookup index comes in on one cycle, and the matching number appears, registered, on the next cycle. A lookup is answered only when virtual functions are enabled and the index lies below the programmed count. A combinational range check flags a configuration whose last virtual function would fall past the end of the 8-bit device/function space.

A second path works in the other direction. When the virtual functions already exist and are described only by their observed device/function numbers, presented in ascending order, the block derives the offset and stride from the first two. It raises a sticky consistency error if the first lies at or below the physical function, or if any later one does not sit exactly its index times the stride above the first. A clear pulse restarts the derivation.

Top module: `vf_rid_gen`

## Requirements
- R1: A lookup of index 0 returns (PF number + offset) modulo 2^FN_W.
- R2: A lookup of index i returns (PF number + offset + i*stride) modulo 2^FN_W, with the sum formed at full width before truncation.
- R3: `cfg_err_o` is 1, combinationally, exactly when total VFs is nonzero and PF number + offset + (total − 1)*stride is at least 2^FN_W (256 by default). With total VFs at 0 it is 0 for any offset or stride.
- R4: `vf_vld_o` is 1 only when, on the previous cycle, `vf_en_i` was 1 and `idx_i` was below `num_vfs_i`. With enable at 0 the usable count is zero.
- R5: The lookup result is registered: the outputs reflect the inputs of the cycle before. When the result is not valid, `vf_fn_o` is 0, and both lookup outputs are 0 after reset.
- R6: In the observed-ID path, the first accepted number sets `drv_offset_o` = first − PF (mod 2^FN_W), and the second sets `drv_stride_o` = second − first. With a single observation the stride stays 0. The outputs update one cycle after each `obs_vld_i`. Before any observation, and after `obs_clr_i`, offset, stride and error are 0. A clear takes priority over a valid observation in the same cycle.
- R7: If the first observed number is less than or equal to the PF number, `drv_err_o` becomes 1.
- R8: If observation i (i ≥ 1, counted from 0) is below the first, or observation i ≥ 2 is not exactly first + i*stride, `drv_err_o` becomes 1. It stays 1 until `obs_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_fn_i | input | FN_W | Device/function number of the physical function |
| vf_offset_i | input | OFS_W | Offset from the PF to the first VF |
| vf_stride_i | input | OFS_W | Spacing between consecutive VFs |
| total_vfs_i | input | CNT_W | Number of VFs the function can expose |
| num_vfs_i | input | CNT_W | Number of VFs software has chosen |
| vf_en_i | input | 1 | VF enable |
| idx_i | input | CNT_W | VF index to look up |
| vf_fn_o | output | FN_W | Device/function number of the looked-up VF, registered |
| vf_vld_o | output | 1 | Lookup result valid, registered |
| cfg_err_o | output | 1 | Last VF number would overflow the function space |
| obs_clr_i | input | 1 | Restart derivation from observed numbers |
| obs_vld_i | input | 1 | An observed VF number is presented |
| obs_fn_i | input | FN_W | Observed VF device/function number, ascending order |
| drv_offset_o | output | FN_W | Derived offset |
| drv_stride_o | output | FN_W | Derived stride |
| drv_err_o | output | 1 | Sticky consistency error of the derived layout |

## Verification
The assertions check on every cycle that disabled or out-of-range lookups are never valid, that an invalid result reads as zero, that index 0 lands on PF plus offset, that a zero total never flags overflow, and that the derived error holds until cleared. Only the bench scenarios can show the arithmetic at wrap-around, the exact 255/256 boundary of the range check, and the derived offset and stride across single-VF, zero-stride, misplaced-VF and low-first sequences. The reference model is compared against all outputs on every cycle.

// File: rtl/vf_rid_pkg.sv
package vf_rid_pkg;
  typedef enum logic [1:0] {
    OBS_FIRST  = 2'd0,
    OBS_SECOND = 2'd1,
    OBS_REST   = 2'd2
  } obs_phase_e;
endpackage

// File: rtl/vf_rid_range.sv
module vf_rid_range #(
  parameter int FN_W  = 8,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic [FN_W-1:0]  pf_fn_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [OFS_W-1:0] stride_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             err_o
);
  localparam int WIDE_W = FN_W + OFS_W + CNT_W + 1;
  localparam logic [WIDE_W-1:0] LIMIT = WIDE_W'(1) << FN_W;

  logic [CNT_W-1:0]  last_idx;
  logic [WIDE_W-1:0] last_fn;

  always_comb begin
    last_idx = total_i - CNT_W'(1);
    last_fn  = WIDE_W'(pf_fn_i) + WIDE_W'(offset_i)
             + WIDE_W'(last_idx) * WIDE_W'(stride_i);
    err_o    = (total_i != '0) && (last_fn >= LIMIT);
  end
endmodule

// File: rtl/vf_rid_lookup.sv
module vf_rid_lookup #(
  parameter int FN_W  = 8,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FN_W-1:0]  pf_fn_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [OFS_W-1:0] stride_i,
  input  logic [CNT_W-1:0] num_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic [FN_W-1:0]  fn_o,
  output logic             vld_o
);
  localparam int WIDE_W = FN_W + OFS_W + CNT_W + 1;

  logic [CNT_W-1:0]  live_cnt;
  logic              hit;
  logic [WIDE_W-1:0] rid_w;
  logic [FN_W-1:0]   fn_q;
  logic              vld_q;

  always_comb begin
    live_cnt = en_i ? num_i : '0;
    hit      = idx_i < live_cnt;
    rid_w    = WIDE_W'(pf_fn_i) + WIDE_W'(offset_i)
             + WIDE_W'(idx_i) * WIDE_W'(stride_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= hit;
      fn_q  <= hit ? rid_w[FN_W-1:0] : '0;
    end
  end

  assign fn_o  = fn_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/vf_rid_derive.sv
module vf_rid_derive
  import vf_rid_pkg::*;
#(
  parameter int FN_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FN_W-1:0] pf_fn_i,
  input  logic            clr_i,
  input  logic            vld_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [FN_W-1:0] offset_o,
  output logic [FN_W-1:0] stride_o,
  output logic            err_o
);
  localparam int WIDE_W = FN_W + CNT_W + 1;

  obs_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FN_W-1:0]   first_q;
  logic [FN_W-1:0]   stride_q;
  logic              err_q;
  logic [WIDE_W-1:0] span_w;
  logic [WIDE_W-1:0] want_w;
  logic              below_first;

  always_comb begin
    below_first = fn_i < first_q;
    span_w      = WIDE_W'(fn_i) - WIDE_W'(first_q);
    want_w      = WIDE_W'(cnt_q) * WIDE_W'(stride_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= OBS_FIRST;
      cnt_q    <= '0;
      first_q  <= '0;
      stride_q <= '0;
      err_q    <= 1'b0;
    end else if (clr_i) begin
      phase_q  <= OBS_FIRST;
      cnt_q    <= '0;
      first_q  <= '0;
      stride_q <= '0;
      err_q    <= 1'b0;
    end else if (vld_i) begin
      if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
      unique case (phase_q)
        OBS_FIRST: begin
          first_q <= fn_i;
          phase_q <= OBS_SECOND;
          if (fn_i <= pf_fn_i) err_q <= 1'b1;
        end
        OBS_SECOND: begin
          stride_q <= fn_i - first_q;
          phase_q  <= OBS_REST;
          if (below_first) err_q <= 1'b1;
        end
        default: begin
          if (below_first || (span_w != want_w)) err_q <= 1'b1;
        end
      endcase
    end
  end

  assign offset_o = (phase_q == OBS_FIRST) ? '0 : first_q - pf_fn_i;
  assign stride_o = stride_q;
  assign err_o    = err_q;
endmodule

// File: rtl/vf_rid_gen.sv
module vf_rid_gen #(
  parameter int FN_W  = 8,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FN_W-1:0]  pf_fn_i,
  input  logic [OFS_W-1:0] vf_offset_i,
  input  logic [OFS_W-1:0] vf_stride_i,
  input  logic [CNT_W-1:0] total_vfs_i,
  input  logic [CNT_W-1:0] num_vfs_i,
  input  logic             vf_en_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic [FN_W-1:0]  vf_fn_o,
  output logic             vf_vld_o,
  output logic             cfg_err_o,
  input  logic             obs_clr_i,
  input  logic             obs_vld_i,
  input  logic [FN_W-1:0]  obs_fn_i,
  output logic [FN_W-1:0]  drv_offset_o,
  output logic [FN_W-1:0]  drv_stride_o,
  output logic             drv_err_o
);
  vf_rid_range #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_range (
    .pf_fn_i  (pf_fn_i),
    .offset_i (vf_offset_i),
    .stride_i (vf_stride_i),
    .total_i  (total_vfs_i),
    .err_o    (cfg_err_o)
  );

  vf_rid_lookup #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_lookup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pf_fn_i  (pf_fn_i),
    .offset_i (vf_offset_i),
    .stride_i (vf_stride_i),
    .num_i    (num_vfs_i),
    .en_i     (vf_en_i),
    .idx_i    (idx_i),
    .fn_o     (vf_fn_o),
    .vld_o    (vf_vld_o)
  );

  vf_rid_derive #(.FN_W(FN_W), .CNT_W(CNT_W)) u_derive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pf_fn_i  (pf_fn_i),
    .clr_i    (obs_clr_i),
    .vld_i    (obs_vld_i),
    .fn_i     (obs_fn_i),
    .offset_o (drv_offset_o),
    .stride_o (drv_stride_o),
    .err_o    (drv_err_o)
  );
endmodule

// File: rtl/vf_rid_gen_chk.sv
module vf_rid_gen_chk #(
  parameter int FN_W  = 8,
  parameter int OFS_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [FN_W-1:0]  pf_fn_i,
  input logic [OFS_W-1:0] vf_offset_i,
  input logic [CNT_W-1:0] total_vfs_i,
  input logic [CNT_W-1:0] num_vfs_i,
  input logic             vf_en_i,
  input logic [CNT_W-1:0] idx_i,
  input logic [FN_W-1:0]  vf_fn_o,
  input logic             vf_vld_o,
  input logic             cfg_err_o,
  input logic             obs_clr_i,
  input logic [FN_W-1:0]  drv_stride_o,
  input logic             drv_err_o
);
  p_gate_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!vf_en_i) |-> !vf_vld_o);

  p_gate_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(idx_i >= num_vfs_i) |-> !vf_vld_o);

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vf_vld_o |-> (vf_fn_o == '0));

  p_first_vf_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vf_en_i) && ($past(idx_i) == '0) && ($past(num_vfs_i) != '0))
      |-> (vf_fn_o == FN_W'($past(pf_fn_i) + $past(vf_offset_i))));

  p_no_total_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_vfs_i == '0) |-> !cfg_err_o);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(obs_clr_i) |-> (!drv_err_o && (drv_stride_o == '0)));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(drv_err_o) && !$past(obs_clr_i)) |-> drv_err_o);
endmodule

bind vf_rid_gen vf_rid_gen_chk #(.FN_W(FN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pf_fn_i      (pf_fn_i),
  .vf_offset_i  (vf_offset_i),
  .total_vfs_i  (total_vfs_i),
  .num_vfs_i    (num_vfs_i),
  .vf_en_i      (vf_en_i),
  .idx_i        (idx_i),
  .vf_fn_o      (vf_fn_o),
  .vf_vld_o     (vf_vld_o),
  .cfg_err_o    (cfg_err_o),
  .obs_clr_i    (obs_clr_i),
  .drv_stride_o (drv_stride_o),
  .drv_err_o    (drv_err_o)
);

// File: tb/vf_rid_gen_tb_top.sv
module vf_rid_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pf_fn = '0;
  logic [15:0] vf_offset = '0, vf_stride = '0, total_vfs = '0, num_vfs = '0, idx = '0;
  logic        vf_en = 1'b0;
  logic        obs_clr = 1'b0, obs_vld = 1'b0;
  logic [7:0]  obs_fn = '0;
  logic [7:0]  vf_fn, drv_offset, drv_stride;
  logic        vf_vld, cfg_err, drv_err;

  int n_chk = 0, n_fail = 0;
  bit live = 0;
  bit done = 0;

  // reference model state
  int  m_vld, m_fn, m_idx_prev;
  int  m_cnt, m_first, m_stride, m_err;

  vf_rid_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pf_fn_i(pf_fn), .vf_offset_i(vf_offset),
    .vf_stride_i(vf_stride), .total_vfs_i(total_vfs), .num_vfs_i(num_vfs),
    .vf_en_i(vf_en), .idx_i(idx), .vf_fn_o(vf_fn), .vf_vld_o(vf_vld),
    .cfg_err_o(cfg_err), .obs_clr_i(obs_clr), .obs_vld_i(obs_vld),
    .obs_fn_i(obs_fn), .drv_offset_o(drv_offset), .drv_stride_o(drv_stride),
    .drv_err_o(drv_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_fn = 0; m_idx_prev = 0;
      m_cnt = 0; m_first = 0; m_stride = 0; m_err = 0;
    end else begin
      int cnt_live;
      cnt_live   = vf_en ? int'(num_vfs) : 0;
      m_vld      = (int'(idx) < cnt_live) ? 1 : 0;
      m_fn       = m_vld ? ((int'(pf_fn) + int'(vf_offset) + int'(idx) * int'(vf_stride)) % 256) : 0;
      m_idx_prev = int'(idx);
      if (obs_clr) begin
        m_cnt = 0; m_first = 0; m_stride = 0; m_err = 0;
      end else if (obs_vld) begin
        if (m_cnt == 0) begin
          m_first = int'(obs_fn);
          if (int'(obs_fn) <= int'(pf_fn)) m_err = 1;
        end else if (m_cnt == 1) begin
          m_stride = (int'(obs_fn) - m_first + 256) % 256;
          if (int'(obs_fn) < m_first) m_err = 1;
        end else begin
          if (int'(obs_fn) < m_first || (int'(obs_fn) - m_first) != m_cnt * m_stride) m_err = 1;
        end
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      longint last;
      int exp_err;
      last    = longint'(pf_fn) + longint'(vf_offset) + (longint'(total_vfs) - 1) * longint'(vf_stride);
      exp_err = (total_vfs != 0 && last >= 256) ? 1 : 0;
      chk("R4 valid", int'(vf_vld), m_vld);
      chk(m_idx_prev == 0 ? "R1 first VF number" : (m_vld ? "R2 VF number" : "R5 idle number zero"),
          int'(vf_fn), m_fn);
      chk("R3 range error", int'(cfg_err), exp_err);
      chk("R6 derived offset", int'(drv_offset), m_cnt == 0 ? 0 : (m_first - int'(pf_fn) + 256) % 256);
      chk("R6 derived stride", int'(drv_stride), m_stride);
      chk("R7 R8 derived error", int'(drv_err), m_err);
    end
  end

  task automatic cfg(input int pf, input int off, input int str, input int tot, input int num, input bit en);
    @(posedge clk); #1;
    pf_fn = 8'(pf); vf_offset = 16'(off); vf_stride = 16'(str);
    total_vfs = 16'(tot); num_vfs = 16'(num); vf_en = en;
  endtask

  task automatic sweep(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      @(posedge clk); #1; idx = 16'(i);
    end
    @(posedge clk); #1;
  endtask

  task automatic obs(input int fn);
    @(posedge clk); #1; obs_vld = 1'b1; obs_fn = 8'(fn);
    @(posedge clk); #1; obs_vld = 1'b0;
  endtask

  task automatic clr();
    @(posedge clk); #1; obs_clr = 1'b1;
    @(posedge clk); #1; obs_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R5 reset state
    chk("R5 reset valid", int'(vf_vld), 0);
    chk("R5 reset number", int'(vf_fn), 0);
    chk("R6 reset derived error", int'(drv_err), 0);
    rst_n = 1'b1;
    live  = 1;
    // R1 R2 R4: basic contiguous layout, sweep beyond the count
    cfg(0, 1, 1, 8, 4, 1); sweep(0, 9);
    // R4: disabled
    cfg(0, 1, 1, 8, 4, 0); sweep(0, 5);
    // R2: wider stride, offset and PF
    cfg(16, 4, 2, 100, 50, 1); sweep(0, 60);
    // R3: overflow past the end
    cfg(16, 4, 2, 120, 5, 1); sweep(0, 4);
    // R3: exact boundary 255 versus 256
    cfg(0, 1, 1, 255, 3, 1); sweep(250, 256);
    cfg(0, 1, 1, 256, 3, 1); sweep(0, 3);
    // R3: total zero with huge offset and stride
    cfg(200, 60000, 9000, 0, 2, 1); sweep(0, 2);
    // R2: wrap-around of the lookup result
    cfg(200, 50, 3, 4, 10, 1); sweep(0, 9);
    // R6: consistent sequence
    cfg(2, 0, 0, 0, 0, 0);
    clr(); obs(4); obs(6); obs(8); obs(10);
    // R8: misplaced third
    clr(); obs(4); obs(6); obs(9); obs(11);
    // R6: single VF, stride stays 0
    clr(); obs(5);
    // R6: zero stride with repeats is consistent
    clr(); obs(5); obs(5); obs(5);
    // R7: first at or below PF
    clr(); obs(2); obs(3);
    // R8: later VF below first
    clr(); obs(10); obs(12); obs(8);
    // R6: clear wins over a same-cycle observation
    @(posedge clk); #1; obs_clr = 1'b1; obs_vld = 1'b1; obs_fn = 8'd1;
    @(posedge clk); #1; obs_clr = 1'b0; obs_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule